// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach PHY management registers over a two-wire serial management bus. The host gives it one register request at a time: a select line, a 2-bit opcode, a packed 10-bit address, and 16 bits of write data. The block turns the request into a 64-bit Clause 22 frame. It derives the management clock from the host clock and shifts the frame onto the data line. For reads it releases the line and collects the PHY's reply.

The handshake is started by a pulse and gated by ready. A one-cycle request pulse is accepted only while ready is high and select is high. Ready then stays low until the last bit of the frame has left the line. When ready returns after a read, the reply is already on the read-data bus, and it stays there until the next read completes. A pulse that arrives while a frame is running has no effect.

Top module: `mdio_master`

## Requirements
- R1: A request is accepted only on a clock where `req_i`, `sel_i` and `rdy_o` are all high. `rdy_o` is low from the following cycle, and the first frame bit is on `mdio_o` with `mdio_oe_o` high.
- R2: A request pulse with `sel_i` low, or one that arrives while `rdy_o` is low, has no effect. Ready, the line signals, the running frame and `rdata_o` are all unchanged by it.
- R3: A frame is 64 bits, sent MSB first. Bits 0-31 are ones, bits 32-33 are 0 then 1, and bits 34-35 are `op_i`. Bits 36-40 are `addr_i[9:5]` (PHY number) and bits 41-45 are `addr_i[4:0]` (register number). Bits 46-47 are the turnaround and bits 48-63 are the data.
- R4: For any opcode other than 2'b10, the frame is a write. The turnaround is sent as 1 then 0, the data bits are `wdata_i` as sampled at acceptance (MSB first), and `mdio_oe_o` is high for all 64 bits.
- R5: For opcode 2'b10 (read), `mdio_oe_o` is low from bit 46 to the end of the frame. Each of bits 48-63 is sampled from `mdio_i` at the rising edge of `mdc_o`, first-received bit in `rdata_o[15]`.
- R6: `rdy_o` stays low for exactly 128*(`clk_div_i`+1) clock cycles per frame. After a read, `rdata_o` holds the reply in the same cycle `rdy_o` rises. `rdata_o` changes only when a read completes.
- R7: `mdc_o` is low when idle. Each half period of `mdc_o` lasts `clk_div_i`+1 clock cycles, and each bit starts with a low half. `mdio_o` and `mdio_oe_o` change only at a falling edge of `mdc_o` or at the start of a frame.
- R8: During reset `rdy_o` is 1, `mdc_o` is 0, `mdio_oe_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | MDC half period minus one, in host clocks |
| sel_i | input | 1 | Marks the request as a management access |
| req_i | input | 1 | One-cycle request pulse |
| op_i | input | 2 | Frame opcode (2'b10 read) |
| addr_i | input | 10 | [9:5] PHY number, [4:0] register number |
| wdata_i | input | 16 | Write data, valid with the request pulse |
| rdata_o | output | 16 | Data of the last completed read |
| rdy_o | output | 1 | High when idle and able to accept |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe_o | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data in |

## Verification
The assertions assume that `req_i` is a single-cycle pulse. They also assume that `clk_div_i` is held constant while `rdy_o` is low, since the half-period timing and the line-stability properties depend on a fixed divider over the frame. The stimulus changes the divider and the PHY reply only while the block is idle. It drives `mdio_i` only from a model of the frame position, so a data bit is already settled when the rising MDC edge samples it. Mid-frame and deselected pulses are the only requests issued while ready is low or select is low.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned TA_IDX    = 46;
  localparam int unsigned DATA_IDX  = 48;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned OP_W      = 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam logic [OP_W-1:0] OP_READ = 2'b10;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [OP_W-1:0]   op,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wd
  );
    logic rd;
    rd = (op == OP_READ);
    return {{PRE_LEN{1'b1}}, 2'b01, op, addr[9:5], addr[4:0],
            rd ? 2'b00 : 2'b10, rd ? {DATA_W{1'b0}} : wd};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             hit;

  assign hit = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = hit & ~mdc_q;
  assign fall_o = hit & mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 is_read_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_POS   = CNT_W'(TA_IDX);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(DATA_IDX);

  logic [FRAME_LEN-1:0] sr_q;
  logic [CNT_W-1:0]     bit_q;
  logic [CNT_W-1:0]     nxt;
  logic                 oe_q;
  logic                 rd_q;
  logic [DATA_W-1:0]    cap_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 last;

  assign last   = (bit_q == LAST_POS);
  assign nxt    = bit_q + 1'b1;
  assign done_o = fall_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else if (load_i) begin
      sr_q  <= frame_i;
      bit_q <= '0;
      oe_q  <= 1'b1;
      rd_q  <= is_read_i;
    end else if (fall_i) begin
      if (last) begin
        oe_q <= 1'b0;
      end else begin
        sr_q  <= sr_q << 1;
        bit_q <= nxt;
        oe_q  <= !(rd_q && (nxt >= TA_POS));
      end
    end
  end

  // capture reply on rising MDC during data bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (rise_i && rd_q && (bit_q >= DATA_POS)) begin
      cap_q <= {cap_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (done_o && rd_q) begin
      rdata_q <= cap_q;
    end
  end

  assign mdio_o  = oe_q & sr_q[FRAME_LEN-1];
  assign oe_o    = oe_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mdio_hs.sv
module mdio_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sel_i,
  input  logic done_i,
  output logic accept_o,
  output logic busy_o
);
  logic busy_q;

  assign accept_o = req_i & sel_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (accept_o) busy_q <= 1'b1;
    else if (done_i)   busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              sel_i,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic accept, busy, done, rise, fall;
  logic [FRAME_LEN-1:0] frame;

  assign frame = build_frame(op_i, addr_i, wdata_i);

  mdio_hs u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .sel_i    (sel_i),
    .done_i   (done),
    .accept_o (accept),
    .busy_o   (busy)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (clk_div_i),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .frame_i   (frame),
    .is_read_i (op_i == OP_READ),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .oe_o      (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rdata_o)
  );

  assign rdy_o = ~busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sel_i,
  input logic        req_i,
  input logic [15:0] rdata_o,
  input logic        rdy_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R1
  accept_drops_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && req_i && sel_i) |=> !rdy_o);

  // R2
  no_req_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !(req_i && sel_i)) |=> rdy_o);

  // R6
  rdata_hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && $past(rdy_o)) |-> $stable(rdata_o));

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !mdc_o);

  // R7
  line_on_fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && $past(!rdy_o) && !$fell(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R4
  oe_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> !rdy_o);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .req_i     (req_i),
  .rdata_o   (rdata_o),
  .rdy_o     (rdy_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = 8'd2;
  logic        sel = 1'b0, req = 1'b0, mdio_in = 1'b1;
  logic [1:0]  op = 2'b00;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdy, mdc, mdio_out, mdio_oe;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(div), .sel_i(sel), .req_i(req),
    .op_i(op), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdy_o(rdy),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  bit          m_busy = 0, m_read = 0;
  int          t = 0, m_h = 1;
  logic [63:0] m_frame = '0;
  logic [15:0] m_rdata = '0, phy_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; t = 0; m_rdata = '0;
    end else if (m_busy) begin
      t++;
      if (t == 128 * m_h) begin
        m_busy = 0;
        if (m_read) m_rdata = phy_data;
      end
    end else if (req && sel) begin
      m_busy = 1; t = 0; m_h = int'(div) + 1;
      m_read = (op == 2'b10);
      m_frame = {32'hFFFF_FFFF, 2'b01, op, addr[9:5], addr[4:0],
                 m_read ? 2'b00 : 2'b10, m_read ? 16'h0000 : wdata};
    end
  end

  always @(negedge clk) begin
    int idx;
    bit e_mdc, e_oe;
    cycles++;
    if (rst_n && !finished) begin
      idx   = t / (2 * m_h);
      e_mdc = m_busy && ((t / m_h) % 2 == 1);
      e_oe  = m_busy && !(m_read && idx >= 46);
      chk(rdy == !m_busy, "R6 rdy timing", 64'(rdy), 64'(!m_busy));
      chk(mdc == e_mdc, "R7 mdc", 64'(mdc), 64'(e_mdc));
      chk(mdio_oe == e_oe, m_read ? "R5 oe read" : "R4 oe write", 64'(mdio_oe), 64'(e_oe));
      if (e_oe)
        chk(mdio_out == m_frame[63-idx], "R3 frame bit", 64'(mdio_out), 64'(m_frame[63-idx]));
      chk(rdata == m_rdata, "R5 rdata", 64'(rdata), 64'(m_rdata));
      mdio_in = (m_busy && m_read && idx >= 48) ? phy_data[63-idx] : 1'b1;
    end
  end

  task automatic do_req(input bit s, input logic [1:0] o, input logic [9:0] a, input logic [15:0] w);
    @(negedge clk);
    sel = s; op = o; addr = a; wdata = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0; sel = 1'b0; wdata = '0;
  endtask

  task automatic wait_idle();
    while (!rdy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(rdy == 1'b1, "R8 rdy", 64'(rdy), 64'd1);
    chk(mdc == 1'b0, "R8 mdc", 64'(mdc), 64'd0);
    chk(mdio_oe == 1'b0, "R8 oe", 64'(mdio_oe), 64'd0);
    chk(rdata == 16'h0, "R8 rdata", 64'(rdata), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4 write
    div = 8'd2;
    do_req(1, 2'b01, 10'h2A5, 16'hA5C3);
    wait_idle();
    chk(rdata == 16'h0, "R6 write keeps rdata", 64'(rdata), 64'd0);

    // R5 read
    phy_data = 16'hBEEF;
    do_req(1, 2'b10, 10'h155, 16'h1111);
    wait_idle();
    chk(rdata == 16'hBEEF, "R5 read data", 64'(rdata), 64'hBEEF);

    // R2 deselected pulse
    do_req(0, 2'b01, 10'h3FF, 16'hFFFF);
    chk(rdy == 1'b1, "R2 sel low ignored", 64'(rdy), 64'd1);
    chk(mdio_oe == 1'b0, "R2 sel low line idle", 64'(mdio_oe), 64'd0);

    // R2 mid-frame pulse, fastest divider
    div = 8'd0;
    phy_data = 16'h1234;
    do_req(1, 2'b10, 10'h01F, 16'h0);
    repeat (50) @(negedge clk);
    do_req(1, 2'b01, 10'h3E0, 16'hDEAD);
    wait_idle();
    chk(rdata == 16'h1234, "R2 mid-frame ignored", 64'(rdata), 64'h1234);
    @(negedge clk);
    chk(rdy == 1'b1, "R2 no follow-on frame", 64'(rdy), 64'd1);

    // R4 opcode 00 treated as write, zero data
    div = 8'd3;
    do_req(1, 2'b00, 10'h3FF, 16'h0000);
    wait_idle();
    chk(rdata == 16'h1234, "R6 rdata held over write", 64'(rdata), 64'h1234);

    // R1 back-to-back
    div = 8'd1;
    phy_data = 16'h8001;
    do_req(1, 2'b10, 10'h2AA, 16'h0);
    wait_idle();
    chk(rdata == 16'h8001, "R5 read msb/lsb", 64'(rdata), 64'h8001);
    do_req(1, 2'b11, 10'h0C3, 16'hFFFF);
    chk(rdy == 1'b0, "R1 accept drops rdy", 64'(rdy), 64'd0);
    wait_idle();

    phy_data = 16'h0000;
    do_req(1, 2'b10, 10'h000, 16'hFFFF);
    wait_idle();
    chk(rdata == 16'h0000, "R5 read zeros", 64'(rdata), 64'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
    finish_run();
  end
endmodule